// File: doc/BRIEF.md
# Neighborhood Pattern Test Sequencer

This block is a built-in test sequencer for a two-dimensional single-bit cell array. It looks for static pattern sensitive faults: a cell that takes a wrong value while its four adjacent cells (north, south, east, west) hold one particular 0/1 combination. The array is split like a checkerboard into two groups. While one group serves as base cells, the other group supplies the neighbor patterns. Then the roles swap.

For each group and each base value (0 first, then 1), the sequencer first fills the array. Base cells receive the base value and neighbor cells receive 0. It then reads every base cell. After that it walks the neighbor cells through fifteen more patterns in reflected Gray order. Each step rewrites only the neighbor cells whose pattern bit changed, and every step is followed by a read of all base cells. Each neighbor cell carries a two-bit role that depends on its position. Every base cell sees its four neighbors under four distinct roles, with the array edges wrapping around. As a result, each base cell meets all sixteen neighborhood combinations under both base values. The first mismatching read is latched together with its row, its column and its pattern step.

States: `S_IDLE` (waiting), `S_FILL` (whole-array write), `S_READ` (base-cell read scan), `S_STEP` (rewrite of one neighbor role), `S_DONE` (finished). Transitions:
- `S_IDLE`/`S_DONE` to `S_FILL` on start.
- `S_FILL` to `S_READ` at the last cell.
- `S_READ` to `S_STEP` at the last cell while the step is below 15.
- `S_READ` to `S_FILL` at the last cell of step 15 when a base-value or group pass remains.
- `S_READ` to `S_DONE` after the final pass.
- `S_STEP` to `S_READ` at the last cell.

Top module: `nbr_pattern_tester`

## Requirements
- R1: While reset is held and right after it, `mem_en`, `done` and `err` are 0.
- R2: A fill scans all cells in row-major order, row outer and column inner, writing one cell per cycle. A cell whose (row+col) parity equals the current group gets the base value, and every other cell gets 0. Group 0 is tested before group 1.
- R3: After each fill and after each step, every base cell is read in row-major order with `mem_we`=0, and non-base cells are skipped. Read data is expected on `mem_rdata` in the cycle after the request.
- R4: Pattern step k (1..15) uses the Gray value g(k)=k^(k>>1). A neighbor cell at (r,c) has role bit0=((r+c)>>1)&1 and bit1=((r-c)>>1)&1, taken modulo 4. In step k, only the neighbor cells whose role equals the index of the single bit where g(k) differs from g(k-1) are written, and they receive bit role of g(k).
- R5: Neighborhoods wrap at the array edges (ROWS and COLS are multiples of 4), so an edge base cell is still exercised with all sixteen neighbor combinations.
- R6: Within each group, the complete fill, read and step sequence runs with base value 0 and then with base value 1. The fill that starts the second pass resets the neighbor cells to 0.
- R7: The first base-cell read that differs from the base value sets `err`, which stays set until the next start. `err_row`, `err_col` and `err_pat` (the step index k) capture that first mismatch only.
- R8: `done` rises once all four passes finish and the last read has been compared. `mem_en` is then 0. A new start clears `err`, drops `done` and reruns the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a test run when idle or done |
| mem_en | output | 1 | Array access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_row | output | RW | Row address |
| mem_col | output | CW | Column address |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data, one cycle after a read request |
| done | output | 1 | Test sequence complete |
| err | output | 1 | Sticky mismatch flag |
| err_row | output | RW | Row of first mismatch |
| err_col | output | CW | Column of first mismatch |
| err_pat | output | 4 | Pattern step of first mismatch |

## Verification
A scoreboard compares every array access against the full expected operation stream. A design that writes extra neighbor cells, skips the rewrite fill, reads in the wrong order or scans the groups in the wrong order therefore shows up at the first diverging access. Injected neighborhood faults probe the remaining corners:
- A corner cell whose neighbors wrap across both edges. A design with broken wrap or role labeling would never reach the sensitizing combination.
- A fault that forces 0 and so only appears in the base-value-1 pass. It catches a sequencer that drops or reorders that pass, or one that reports the wrong step.
- A group-1 cell, which catches a design that never swaps roles.

A restart after a failure checks that the flag clears.

// File: rtl/nbr_pattern_pkg.sv
package nbr_pattern_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_READ,
        S_STEP,
        S_DONE
    } seq_state_t;

    // Two-bit neighbor role; distinct for the four neighbors of any base cell.
    function automatic logic [1:0] role_of(input logic [15:0] r, input logic [15:0] c);
        logic [15:0] s;
        logic [15:0] d;
        s = r + c;
        d = r - c;
        return {d[1], s[1]};
    endfunction

    function automatic logic [3:0] gray4(input logic [3:0] k);
        return k ^ (k >> 1);
    endfunction

endpackage

// File: rtl/nbr_scan.sv
module nbr_scan #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          last
);
    localparam logic [RW-1:0] RMAX = RW'(ROWS - 1);
    localparam logic [CW-1:0] CMAX = CW'(COLS - 1);

    assign last = (row == RMAX) && (col == CMAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (adv) begin
            if (col == CMAX) begin
                col <= '0;
                row <= (row == RMAX) ? '0 : row + RW'(1);
            end else begin
                col <= col + CW'(1);
            end
        end
    end

    // R2: after the last cell the scan restarts at the origin
    p_scan_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (row == '0 && col == '0));

endmodule

// File: rtl/nbr_check.sv
module nbr_check #(
    parameter int RW = 3,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rd_issue,
    input  logic [RW-1:0] rd_row,
    input  logic [CW-1:0] rd_col,
    input  logic [3:0]    rd_pat,
    input  logic          exp_bit,
    input  logic          rdata,
    output logic          pend,
    output logic          err,
    output logic [RW-1:0] err_row,
    output logic [CW-1:0] err_col,
    output logic [3:0]    err_pat
);
    logic [RW-1:0] q_row;
    logic [CW-1:0] q_col;
    logic [3:0]    q_pat;
    logic          q_exp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            q_row   <= '0;
            q_col   <= '0;
            q_pat   <= '0;
            q_exp   <= 1'b0;
            err     <= 1'b0;
            err_row <= '0;
            err_col <= '0;
            err_pat <= '0;
        end else begin
            pend <= rd_issue;
            if (rd_issue) begin
                q_row <= rd_row;
                q_col <= rd_col;
                q_pat <= rd_pat;
                q_exp <= exp_bit;
            end
            if (clear) begin
                err <= 1'b0;
            end else if (pend && (rdata != q_exp) && !err) begin
                err     <= 1'b1;
                err_row <= q_row;
                err_col <= q_col;
                err_pat <= q_pat;
            end
        end
    end

    // R7: the flag holds until a new run clears it
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear) |=> err);

    // R7: captured location frozen once flagged
    p_capture_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear) |=> ($stable(err_row) && $stable(err_col) && $stable(err_pat)));

endmodule

// File: rtl/nbr_pattern_tester.sv
module nbr_pattern_tester
    import nbr_pattern_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          mem_en,
    output logic          mem_we,
    output logic [RW-1:0] mem_row,
    output logic [CW-1:0] mem_col,
    output logic          mem_wdata,
    input  logic          mem_rdata,
    output logic          done,
    output logic          err,
    output logic [RW-1:0] err_row,
    output logic [CW-1:0] err_col,
    output logic [3:0]    err_pat
);
    localparam logic [3:0] LAST_STEP = 4'd15;

    seq_state_t    state;
    logic          grp;
    logic          bval;
    logic [3:0]    kstep;
    logic [RW-1:0] row;
    logic [CW-1:0] col;
    logic          last;
    logic          busy;
    logic          is_base;
    logic [1:0]    role;
    logic [3:0]    gcur;
    logic [3:0]    chg;
    logic          launch;
    logic          rd_issue;
    logic          pend;

    assign busy    = (state == S_FILL) || (state == S_READ) || (state == S_STEP);
    assign is_base = (row[0] ^ col[0]) == grp;
    assign role    = role_of(16'(row), 16'(col));
    assign gcur    = gray4(kstep);
    assign chg     = gcur ^ gray4(kstep - 4'd1);
    assign launch  = start && ((state == S_IDLE) || (state == S_DONE));
    assign rd_issue = (state == S_READ) && is_base;

    nbr_scan #(.ROWS(ROWS), .COLS(COLS)) u_scan (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (busy),
        .row  (row),
        .col  (col),
        .last (last)
    );

    nbr_check #(.RW(RW), .CW(CW)) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .rd_issue(rd_issue),
        .rd_row  (row),
        .rd_col  (col),
        .rd_pat  (kstep),
        .exp_bit (bval),
        .rdata   (mem_rdata),
        .pend    (pend),
        .err     (err),
        .err_row (err_row),
        .err_col (err_col),
        .err_pat (err_pat)
    );

    // State register and pass counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            grp   <= 1'b0;
            bval  <= 1'b0;
            kstep <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        state <= S_FILL;
                        grp   <= 1'b0;
                        bval  <= 1'b0;
                        kstep <= '0;
                    end
                end
                S_FILL: if (last) state <= S_READ;
                S_STEP: if (last) state <= S_READ;
                S_READ: begin
                    if (last) begin
                        if (kstep != LAST_STEP) begin
                            kstep <= kstep + 4'd1;
                            state <= S_STEP;
                        end else if (!bval) begin
                            bval  <= 1'b1;
                            kstep <= '0;
                            state <= S_FILL;
                        end else if (!grp) begin
                            grp   <= 1'b1;
                            bval  <= 1'b0;
                            kstep <= '0;
                            state <= S_FILL;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Array access outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = 1'b0;
        unique case (state)
            S_FILL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = is_base ? bval : gcur[role];
            end
            S_READ: begin
                mem_en = is_base;
            end
            S_STEP: begin
                mem_en    = !is_base && chg[role];
                mem_we    = 1'b1;
                mem_wdata = gcur[role];
            end
            default: ;
        endcase
    end

    assign mem_row = row;
    assign mem_col = col;
    assign done    = (state == S_DONE) && !pend;

    // R4: each step changes exactly one neighbor role
    p_one_role_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP) |-> ($countones(chg) == 1));

    // R3: pattern index is held for a whole read scan
    p_pattern_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && !last) |=> $stable(kstep));

    // R8: finished state persists until a new start
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !start) |=> (state == S_DONE && !mem_en));

    // R6: a new base-value pass always begins with a fill at pattern 0
    p_pass_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |-> (kstep == 4'd0));

endmodule

// File: tb/nbr_pattern_tester_bench.sv
module nbr_pattern_tester_bench;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);

    typedef struct packed {
        logic          we;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          wdata;
    } op_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_en, mem_we, mem_wdata;
    logic          mem_rdata = 1'b0;
    logic [RW-1:0] mem_row;
    logic [CW-1:0] mem_col;
    logic          done, err;
    logic [RW-1:0] err_row;
    logic [CW-1:0] err_col;
    logic [3:0]    err_pat;

    int n_checks = 0;
    int n_fail = 0;
    op_t exp_q[$];

    logic mem [ROWS][COLS];
    logic fault_on = 1'b0;
    int   f_row = 0, f_col = 0, f_pat = 0;
    logic f_val = 1'b0;

    always #5 clk = ~clk;

    nbr_pattern_tester #(.ROWS(ROWS), .COLS(COLS)) u_nbr_pattern_tester (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_en(mem_en), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .err(err), .err_row(err_row), .err_col(err_col), .err_pat(err_pat)
    );

    function automatic int gray(int k);
        return k ^ (k >> 1);
    endfunction

    function automatic int role(int r, int c);
        return (((r + c) >> 1) & 1) | ((((r - c + 4 * ROWS) >> 1) & 1) << 1);
    endfunction

    // N,S,E,W neighbor bits of (r,c) as bits 3..0
    function automatic int nbhd(int r, int c);
        int rn = (r + ROWS - 1) % ROWS;
        int rs = (r + 1) % ROWS;
        int ce = (c + 1) % COLS;
        int cw = (c + COLS - 1) % COLS;
        return (int'(mem[rn][c]) << 3) | (int'(mem[rs][c]) << 2) |
               (int'(mem[r][ce]) << 1) | int'(mem[r][cw]);
    endfunction

    // Array model with one-cycle read latency and optional pattern fault
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_row][mem_col] <= mem_wdata;
            else if (fault_on && int'(mem_row) == f_row && int'(mem_col) == f_col &&
                     nbhd(f_row, f_col) == f_pat)
                mem_rdata <= f_val;
            else
                mem_rdata <= mem[mem_row][mem_col];
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: push the full expected operation stream (R2, R3, R4, R6)
    task automatic push_ops();
        for (int g = 0; g < 2; g++) begin
            for (int bv = 0; bv < 2; bv++) begin
                for (int k = 0; k < 16; k++) begin
                    for (int r = 0; r < ROWS; r++) begin
                        for (int c = 0; c < COLS; c++) begin
                            bit base = ((r + c) % 2) == g;
                            op_t o;
                            o.row = RW'(r);
                            o.col = CW'(c);
                            if (k == 0) begin
                                o.we = 1'b1;
                                o.wdata = base ? 1'(bv) : 1'b0;
                                exp_q.push_back(o);
                            end else if (!base &&
                                         (((gray(k) ^ gray(k - 1)) >> role(r, c)) & 1) == 1) begin
                                o.we = 1'b1;
                                o.wdata = 1'((gray(k) >> role(r, c)) & 1);
                                exp_q.push_back(o);
                            end
                        end
                    end
                    for (int r = 0; r < ROWS; r++) begin
                        for (int c = 0; c < COLS; c++) begin
                            if (((r + c) % 2) == g) begin
                                op_t o;
                                o.we = 1'b0;
                                o.row = RW'(r);
                                o.col = CW'(c);
                                o.wdata = 1'b0;
                                exp_q.push_back(o);
                            end
                        end
                    end
                end
            end
        end
    endtask

    // Monitor: pop and compare every access
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected access", 1, 0);
            end else begin
                op_t e;
                op_t a;
                e = exp_q.pop_front();
                a = '{we: mem_we, row: mem_row, col: mem_col, wdata: mem_we ? mem_wdata : 1'b0};
                check(a == e, e.we ? "R4" : "R3", "access {we,row,col,data}",
                      int'(a), int'(e));
            end
        end
    end

    // Expected first detection for the injected fault (R5, R6, R7)
    task automatic expect_fault(output int er, output int ec, output int ek);
        bit found = 0;
        er = -1; ec = -1; ek = -1;
        for (int g = 0; g < 2 && !found; g++)
            for (int bv = 0; bv < 2 && !found; bv++)
                for (int k = 0; k < 16 && !found; k++) begin
                    int nb;
                    if (((f_row + f_col) % 2) == g && int'(f_val) != bv) begin
                        nb = (((gray(k) >> role((f_row + ROWS - 1) % ROWS, f_col)) & 1) << 3) |
                             (((gray(k) >> role((f_row + 1) % ROWS, f_col)) & 1) << 2) |
                             (((gray(k) >> role(f_row, (f_col + 1) % COLS)) & 1) << 1) |
                             ((gray(k) >> role(f_row, (f_col + COLS - 1) % COLS)) & 1);
                        if (nb == f_pat) begin
                            found = 1; er = f_row; ec = f_col; ek = k;
                        end
                    end
                end
    endtask

    task automatic run(input string tag, input bit faulty);
        int cyc = 0;
        push_ops();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8", "done after start", int'(done), 0);
        check(err == 1'b0, "R8", "err cleared by start", int'(err), 0);
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 20000, "R8", {tag, " watchdog"}, cyc, 0);
        check(exp_q.size() == 0, "R2", {tag, " ops left"}, exp_q.size(), 0);
        exp_q.delete();
        check(mem_en == 1'b0, "R8", "idle when done", int'(mem_en), 0);
        if (!faulty) begin
            check(err == 1'b0, "R7", {tag, " clean err"}, int'(err), 0);
        end else begin
            int er, ec, ek;
            expect_fault(er, ec, ek);
            check(err == 1'b1, "R7", {tag, " err"}, int'(err), 1);
            check(int'(err_row) == er, "R7", {tag, " err_row"}, int'(err_row), er);
            check(int'(err_col) == ec, "R5", {tag, " err_col"}, int'(err_col), ec);
            check(int'(err_pat) == ek, "R6", {tag, " err_pat"}, int'(err_pat), ek);
        end
        @(negedge clk);
        check(done == 1'b1, "R8", "done holds", int'(done), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                mem[r][c] = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_en == 1'b0, "R1", "mem_en in reset", int'(mem_en), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(err == 1'b0, "R1", "err in reset", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_en == 1'b0 && done == 1'b0, "R1", "idle after reset", int'(mem_en), 0);

        run("clean", 1'b0);

        // corner cell, inverted when N,S,E,W = 1,0,1,1; wraps on both axes
        fault_on = 1'b1; f_row = 0; f_col = 0; f_pat = 4'b1011; f_val = 1'b1;
        run("corner", 1'b1);

        // group-1 cell forced to 0: only visible with base value 1
        f_row = 5; f_col = 2; f_pat = 4'b0110; f_val = 1'b0;
        run("group1_bv1", 1'b1);

        fault_on = 1'b0;
        run("restart", 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule